// File: doc/BRIEF.md
# Baseline Locomotive Packet Decoder

This block sits behind a bit classifier that has already turned track transitions into one-cycle strobes carrying a bit value. It finds a run of one bits long enough to count as a preamble and frames the three bytes that follow. It checks the third byte against the XOR of the first two. It then acts on the packet when the packet targets this locomotive's 7-bit address, is a decoder reset, or is a broadcast stop. The result is a set of registered motor commands: a speed step from 0 to 28, a direction, a normal-stop flag and a power-cut (emergency) flag.

Framing is done by a state machine with the states FR_PREAMBLE, FR_ADDR, FR_SEP1, FR_INSTR, FR_SEP2, FR_CHECK and FR_TAIL. These are its transitions:
- FR_PREAMBLE to FR_ADDR on a zero bit after at least the minimum run of ones.
- FR_ADDR to FR_SEP1 after eight bits.
- FR_SEP1 to FR_INSTR on a zero bit. A one bit is a framing error and returns to FR_PREAMBLE.
- FR_INSTR to FR_SEP2 after eight bits.
- FR_SEP2 to FR_CHECK on a zero bit. A one bit returns to FR_PREAMBLE.
- FR_CHECK to FR_TAIL after eight bits.
- FR_TAIL to FR_PREAMBLE always. An end bit of one also emits the frame strobe.

A command stage classifies each framed packet into one of four kinds:
- CMD_RESET
- CMD_BCAST
- CMD_LOCO
- CMD_NONE

It then updates the outputs.

Top module: `dcc_loco_decoder`

## Requirements
- R1: After reset, speed_step is 0, dir_fwd is 0, motor_halt is 1, power_cut is 0 and pkt_accept is 0.
- R2: A packet is framed only if at least MIN_PREAMBLE (10) consecutive one bits come directly before its start zero. Ten ones are enough and nine are not.
- R3: Bytes are taken MSB first. A one bit where a byte-separating zero is expected, or a zero bit where the final one is expected, discards the packet. Decoding resumes only after a new full preamble.
- R4: An instruction byte 01DCSSSS (bits 7:6 = 01, D = bit 5, C = bit 4, S = bits 3:0) sent to own_addr with S in 2..15 sets speed_step to (S-2)*2 + C + 1 and dir_fwd to D (1 = forward). It also clears motor_halt and power_cut.
- R5: A packet whose third byte differs from the XOR of the first two has no effect on any output.
- R6: For own-address speed packets, S = 0 (codes 0 and 16) gives motor_halt=1 and power_cut=0. S = 1 (codes 1 and 17) gives power_cut=1 and motor_halt=0. Both give speed_step 0 and take dir_fwd from D. The two flags are never high together.
- R7: An address byte with bit 7 set, a 7-bit address other than own_addr, or an instruction whose bits 7:6 are not 01, leaves the outputs unchanged.
- R8: The all-zero packet (0x00, 0x00, 0x00) restores the R1 output values and pulses pkt_accept.
- R9: The idle packet (0xFF, 0x00, 0xFF) changes no output and does not pulse pkt_accept.
- R10: Address 0x00 with instruction 01DC000S and a matching check byte is a broadcast stop. S=0 sets motor_halt, S=1 sets power_cut, speed_step becomes 0, and dir_fwd keeps its value.
- R11: pkt_accept is high for exactly one clock for each accepted packet (own speed, reset, broadcast stop). That clock is the second rising edge after the end-bit strobe is sampled, which is also the edge at which the outputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle strobe: a classified bit is present |
| bit_val | input | 1 | Value of the strobed bit |
| own_addr | input | 7 | This decoder's address, 1..127 |
| speed_step | output | 5 | Current speed step, 0..28 |
| dir_fwd | output | 1 | 1 = forward, 0 = reverse |
| motor_halt | output | 1 | Normal stop commanded |
| power_cut | output | 1 | Motor power removed (emergency stop) |
| pkt_accept | output | 1 | One-clock pulse when a packet updated the outputs |

## Verification
The assertions assume the following about the inputs:
- bit_stb is a single-cycle strobe.
- own_addr is non-zero and stays constant while packets arrive.

Because a packet spans dozens of strobes, two frame strobes can never fall on adjacent clocks. The pulse-width and single-strobe properties rely on that spacing. The stimulus keeps to these assumptions: every bit is a one-clock strobe followed by a clear clock, own_addr is fixed at 3 for the whole run, and every corrupted packet is followed by a complete fresh preamble.

// File: rtl/dcc_dec_pkg.sv
package dcc_dec_pkg;
    typedef enum logic [2:0] {
        FR_PREAMBLE,
        FR_ADDR,
        FR_SEP1,
        FR_INSTR,
        FR_SEP2,
        FR_CHECK,
        FR_TAIL
    } frame_state_t;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_RESET,
        CMD_BCAST,
        CMD_LOCO
    } cmd_kind_t;

    localparam int unsigned MAX_STEP = 28;
endpackage

// File: rtl/dcc_frame_rx.sv
module dcc_frame_rx
    import dcc_dec_pkg::*;
#(
    parameter int unsigned MIN_PRE = 10,
    parameter int unsigned BYTE_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    output logic              frm_stb,
    output logic [BYTE_W-1:0] frm_addr,
    output logic [BYTE_W-1:0] frm_instr,
    output logic [BYTE_W-1:0] frm_chk
);
    localparam int unsigned PRE_W = $clog2(MIN_PRE + 1);
    localparam int unsigned CNT_W = $clog2(BYTE_W);
    localparam logic [PRE_W-1:0] PRE_FULL = PRE_W'(MIN_PRE);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W - 1);

    frame_state_t      state, nxt;
    logic [PRE_W-1:0]  pre_cnt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] byte_now;
    logic              last_bit;

    assign byte_now = {shreg[BYTE_W-2:0], bit_val};
    assign last_bit = (bit_cnt == BIT_LAST);

    always_comb begin
        nxt = state;
        if (bit_stb) begin
            unique case (state)
                FR_PREAMBLE: if (!bit_val && pre_cnt == PRE_FULL) nxt = FR_ADDR;
                FR_ADDR:     if (last_bit) nxt = FR_SEP1;
                FR_SEP1:     nxt = bit_val ? FR_PREAMBLE : FR_INSTR;
                FR_INSTR:    if (last_bit) nxt = FR_SEP2;
                FR_SEP2:     nxt = bit_val ? FR_PREAMBLE : FR_CHECK;
                FR_CHECK:    if (last_bit) nxt = FR_TAIL;
                FR_TAIL:     nxt = FR_PREAMBLE;
                default:     nxt = FR_PREAMBLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= FR_PREAMBLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_cnt   <= '0;
            bit_cnt   <= '0;
            shreg     <= '0;
            frm_stb   <= 1'b0;
            frm_addr  <= '0;
            frm_instr <= '0;
            frm_chk   <= '0;
        end else begin
            frm_stb <= 1'b0;
            if (bit_stb) begin
                unique case (state)
                    FR_PREAMBLE: begin
                        bit_cnt <= '0;
                        if (!bit_val)                pre_cnt <= '0;
                        else if (pre_cnt != PRE_FULL) pre_cnt <= pre_cnt + 1'b1;
                    end
                    FR_ADDR, FR_INSTR, FR_CHECK: begin
                        shreg   <= byte_now;
                        bit_cnt <= last_bit ? '0 : bit_cnt + 1'b1;
                        if (last_bit) begin
                            if (state == FR_ADDR)  frm_addr  <= byte_now;
                            if (state == FR_INSTR) frm_instr <= byte_now;
                            if (state == FR_CHECK) frm_chk   <= byte_now;
                        end
                    end
                    FR_SEP1, FR_SEP2: pre_cnt <= '0;
                    FR_TAIL: begin
                        pre_cnt <= '0;
                        frm_stb <= bit_val;
                    end
                    default: pre_cnt <= '0;
                endcase
            end
        end
    end

    // R2: the address byte is entered only from a saturated run of ones
    assert_preamble_min_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == FR_ADDR && $past(state) == FR_PREAMBLE) |-> $past(pre_cnt) == PRE_FULL);

    // R3: a framed packet is announced for a single clock only
    assert_frame_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stb |=> !frm_stb);

    // R3: the frame strobe follows a one bit accepted while in the tail state
    assert_frame_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
        frm_stb |-> ($past(state) == FR_TAIL && $past(bit_stb) && $past(bit_val)));
endmodule

// File: rtl/dcc_speed_map.sv
module dcc_speed_map #(
    parameter int unsigned S_W    = 4,
    parameter int unsigned STEP_W = 5
) (
    input  logic [S_W-1:0]    s_bits,
    input  logic              c_bit,
    output logic [STEP_W-1:0] step,
    output logic              is_stop,
    output logic              is_estop
);
    logic [S_W-1:0] s_less2;

    assign s_less2  = s_bits - S_W'(2);
    assign is_stop  = (s_bits == '0);
    assign is_estop = (s_bits == S_W'(1));

    always_comb begin
        if (is_stop || is_estop) step = '0;
        else                     step = STEP_W'({s_less2, c_bit}) + STEP_W'(1);
    end

    // R4: mapped steps never exceed the top of the table
    always_comb begin
        assert_step_range_R4: assert (step <= STEP_W'(dcc_dec_pkg::MAX_STEP));
    end
endmodule

// File: rtl/dcc_cmd_exec.sv
module dcc_cmd_exec
    import dcc_dec_pkg::*;
#(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned BYTE_W = 8,
    parameter int unsigned STEP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_stb,
    input  logic [BYTE_W-1:0] frm_addr,
    input  logic [BYTE_W-1:0] frm_instr,
    input  logic [BYTE_W-1:0] frm_chk,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic [STEP_W-1:0] map_step,
    input  logic              map_stop,
    input  logic              map_estop,
    output logic [STEP_W-1:0] speed_step,
    output logic              dir_fwd,
    output logic              motor_halt,
    output logic              power_cut,
    output logic              pkt_accept
);
    cmd_kind_t kind;
    logic      chk_ok;
    logic      speed_form;

    assign chk_ok     = (frm_chk == (frm_addr ^ frm_instr));
    assign speed_form = (frm_instr[BYTE_W-1 -: 2] == 2'b01);

    always_comb begin
        kind = CMD_NONE;
        if (frm_addr == '0 && frm_instr == '0)
            kind = CMD_RESET;
        else if (frm_addr == '0 && speed_form && frm_instr[3:1] == 3'b000)
            kind = CMD_BCAST;
        else if (frm_addr[BYTE_W-1:ADDR_W] == '0 && frm_addr[ADDR_W-1:0] == own_addr
                 && speed_form)
            kind = CMD_LOCO;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            speed_step <= '0;
            dir_fwd    <= 1'b0;
            motor_halt <= 1'b1;
            power_cut  <= 1'b0;
            pkt_accept <= 1'b0;
        end else begin
            pkt_accept <= 1'b0;
            if (frm_stb && chk_ok) begin
                unique case (kind)
                    CMD_RESET: begin
                        speed_step <= '0;
                        dir_fwd    <= 1'b0;
                        motor_halt <= 1'b1;
                        power_cut  <= 1'b0;
                        pkt_accept <= 1'b1;
                    end
                    CMD_BCAST: begin
                        speed_step <= '0;
                        motor_halt <= ~frm_instr[0];
                        power_cut  <= frm_instr[0];
                        pkt_accept <= 1'b1;
                    end
                    CMD_LOCO: begin
                        speed_step <= map_step;
                        dir_fwd    <= frm_instr[5];
                        motor_halt <= map_stop;
                        power_cut  <= map_estop;
                        pkt_accept <= 1'b1;
                    end
                    CMD_NONE: ;
                    default: ;
                endcase
            end
        end
    end

    // R6: stop and power cut are never commanded together
    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(motor_halt && power_cut));

    // R6: any halt state carries a zero speed step
    assert_halt_zero_speed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (motor_halt || power_cut) |-> speed_step == '0);

    // R11: acceptance follows a frame strobe and lasts one clock
    assert_accept_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_accept |-> $past(frm_stb));
    assert_accept_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_accept |=> !pkt_accept);

    // R5: outputs only move when an accepted packet is reported
    assert_hold_unless_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_accept |-> ($stable(speed_step) && $stable(dir_fwd) && $stable(power_cut)));
endmodule

// File: rtl/dcc_loco_decoder.sv
module dcc_loco_decoder #(
    parameter int unsigned MIN_PREAMBLE = 10,
    parameter int unsigned ADDR_W       = 7,
    parameter int unsigned BYTE_W       = 8,
    parameter int unsigned STEP_W       = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              bit_val,
    input  logic [ADDR_W-1:0] own_addr,
    output logic [STEP_W-1:0] speed_step,
    output logic              dir_fwd,
    output logic              motor_halt,
    output logic              power_cut,
    output logic              pkt_accept
);
    logic              frm_stb;
    logic [BYTE_W-1:0] frm_addr, frm_instr, frm_chk;
    logic [STEP_W-1:0] map_step;
    logic              map_stop, map_estop;

    dcc_frame_rx #(.MIN_PRE(MIN_PREAMBLE), .BYTE_W(BYTE_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .frm_stb(frm_stb), .frm_addr(frm_addr), .frm_instr(frm_instr), .frm_chk(frm_chk)
    );

    dcc_speed_map #(.S_W(4), .STEP_W(STEP_W)) u_map (
        .s_bits(frm_instr[3:0]), .c_bit(frm_instr[4]),
        .step(map_step), .is_stop(map_stop), .is_estop(map_estop)
    );

    dcc_cmd_exec #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .STEP_W(STEP_W)) u_exec (
        .clk(clk), .rst_n(rst_n), .frm_stb(frm_stb),
        .frm_addr(frm_addr), .frm_instr(frm_instr), .frm_chk(frm_chk),
        .own_addr(own_addr), .map_step(map_step), .map_stop(map_stop), .map_estop(map_estop),
        .speed_step(speed_step), .dir_fwd(dir_fwd), .motor_halt(motor_halt),
        .power_cut(power_cut), .pkt_accept(pkt_accept)
    );
endmodule

// File: tb/dcc_loco_decoder_test.sv
`timescale 1ns/1ps
module dcc_loco_decoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0;
    logic       bit_val = 1'b0;
    logic [6:0] own_addr = 7'd3;
    logic [4:0] speed_step;
    logic       dir_fwd, motor_halt, power_cut, pkt_accept;

    int total = 0;
    int bad = 0;
    int acc_cnt = 0;

    always #2 clk = ~clk;

    dcc_loco_decoder uut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .own_addr(own_addr), .speed_step(speed_step), .dir_fwd(dir_fwd),
        .motor_halt(motor_halt), .power_cut(power_cut), .pkt_accept(pkt_accept)
    );

    always @(negedge clk) if (pkt_accept) acc_cnt++;

    task automatic check(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic expect_out(input string req, input int sp, input int dr,
                              input int hl, input int pc);
        check(req, "speed_step", speed_step, sp);
        check(req, "dir_fwd", dir_fwd, dr);
        check(req, "motor_halt", motor_halt, hl);
        check(req, "power_cut", power_cut, pc);
    endtask

    function automatic logic [7:0] mk(input bit d, input bit c, input logic [3:0] s);
        return {2'b01, d, c, s};
    endfunction

    task automatic send_bit(input bit b);
        @(negedge clk);
        bit_stb = 1'b1;
        bit_val = b;
        @(negedge clk);
        bit_stb = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int k = 7; k >= 0; k--) send_bit(v[k]);
    endtask

    // err: 0 none, 1 first separator sent as one, 2 end bit sent as zero
    task automatic send_raw(input int npre, input logic [7:0] a, input logic [7:0] i,
                            input logic [7:0] c, input int err, input bit settle);
        for (int k = 0; k < npre; k++) send_bit(1'b1);
        send_bit(1'b0);
        send_byte(a);
        send_bit(err == 1);
        send_byte(i);
        send_bit(1'b0);
        send_byte(c);
        send_bit(err != 2);
        if (settle) repeat (4) @(negedge clk);
    endtask

    task automatic send_pkt(input int npre, input logic [7:0] a, input logic [7:0] i);
        send_raw(npre, a, i, a ^ i, 0, 1'b1);
    endtask

    task automatic t_reset_state;
        expect_out("R1", 0, 0, 1, 0);
        check("R1", "pkt_accept", pkt_accept, 0);
    endtask

    task automatic t_speed;
        int a0 = acc_cnt;
        send_pkt(12, 8'h03, mk(1, 1, 4'd4));
        expect_out("R4", 6, 1, 0, 0);
        check("R11", "accept count", acc_cnt - a0, 1);
        send_pkt(12, 8'h03, mk(0, 1, 4'd15));
        expect_out("R4", 28, 0, 0, 0);
        send_pkt(14, 8'h03, mk(1, 0, 4'd2));
        expect_out("R4", 1, 1, 0, 0);
    endtask

    task automatic t_preamble;
        int a0 = acc_cnt;
        send_pkt(9, 8'h03, mk(1, 0, 4'd5));
        expect_out("R2", 1, 1, 0, 0);
        check("R2", "no accept on 9 ones", acc_cnt - a0, 0);
        send_pkt(10, 8'h03, mk(1, 0, 4'd5));
        expect_out("R2", 7, 1, 0, 0);
    endtask

    task automatic t_check_byte;
        int a0 = acc_cnt;
        send_raw(12, 8'h03, mk(0, 0, 4'd9), 8'h03 ^ mk(0, 0, 4'd9) ^ 8'h01, 0, 1'b1);
        expect_out("R5", 7, 1, 0, 0);
        check("R5", "no accept", acc_cnt - a0, 0);
    endtask

    task automatic t_addr_filter;
        int a0 = acc_cnt;
        send_pkt(12, 8'h04, mk(0, 0, 4'd9));
        expect_out("R7", 7, 1, 0, 0);
        send_pkt(12, 8'h83, mk(0, 0, 4'd9));
        expect_out("R7", 7, 1, 0, 0);
        send_pkt(12, 8'h03, 8'hC5);
        expect_out("R7", 7, 1, 0, 0);
        check("R7", "no accept", acc_cnt - a0, 0);
    endtask

    task automatic t_framing;
        int a0 = acc_cnt;
        send_raw(12, 8'h03, mk(0, 0, 4'd9), 8'h03 ^ mk(0, 0, 4'd9), 1, 1'b1);
        expect_out("R3", 7, 1, 0, 0);
        send_raw(12, 8'h03, mk(0, 0, 4'd9), 8'h03 ^ mk(0, 0, 4'd9), 2, 1'b1);
        expect_out("R3", 7, 1, 0, 0);
        check("R3", "no accept on bad framing", acc_cnt - a0, 0);
        send_pkt(12, 8'h03, mk(0, 0, 4'd3));
        expect_out("R3", 3, 0, 0, 0);
    endtask

    task automatic t_stops;
        send_pkt(12, 8'h03, mk(1, 0, 4'd1));
        expect_out("R6", 0, 1, 0, 1);
        send_pkt(12, 8'h03, mk(0, 1, 4'd0));
        expect_out("R6", 0, 0, 1, 0);
    endtask

    task automatic t_idle;
        int a0;
        send_pkt(12, 8'h03, mk(1, 1, 4'd4));
        a0 = acc_cnt;
        send_pkt(12, 8'hFF, 8'h00);
        expect_out("R9", 6, 1, 0, 0);
        check("R9", "no accept", acc_cnt - a0, 0);
    endtask

    task automatic t_broadcast;
        int a0 = acc_cnt;
        send_pkt(12, 8'h00, mk(0, 0, 4'd0));
        expect_out("R10", 0, 1, 1, 0);
        check("R10", "accept", acc_cnt - a0, 1);
        send_pkt(12, 8'h03, mk(1, 1, 4'd4));
        send_pkt(12, 8'h00, mk(0, 1, 4'd1));
        expect_out("R10", 0, 1, 0, 1);
    endtask

    task automatic t_reset_pkt;
        int a0;
        send_pkt(12, 8'h03, mk(1, 1, 4'd4));
        a0 = acc_cnt;
        send_pkt(12, 8'h00, 8'h00);
        expect_out("R8", 0, 0, 1, 0);
        check("R8", "accept", acc_cnt - a0, 1);
    endtask

    task automatic t_timing;
        send_raw(12, 8'h03, mk(1, 0, 4'd10), 8'h03 ^ mk(1, 0, 4'd10), 0, 1'b0);
        check("R11", "accept before update", pkt_accept, 0);
        check("R11", "speed before update", speed_step, 0);
        @(negedge clk);
        check("R11", "accept at update", pkt_accept, 1);
        check("R11", "speed at update", speed_step, 17);
        @(negedge clk);
        check("R11", "accept after pulse", pkt_accept, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_speed();
        t_preamble();
        t_check_byte();
        t_addr_filter();
        t_framing();
        t_stops();
        t_idle();
        t_broadcast();
        t_reset_pkt();
        t_timing();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule